// File: doc/BRIEF.md
# Configurable Slice Storage Element Bank

This block holds a group of single-bit storage cells that share one clock, one set/reset line and a global initialise line. Each cell also has its own data input and its own enable. A static configuration word fixes how the whole group behaves. The word is captured on a rising clock edge while `cfg_load` is high. After that it is held and the bank runs as an ordinary group of storage elements.

The first `NUM_PRI` cells are primary cells. They can act either as edge flip-flops or as transparent latches. The remaining `NUM_SEC` cells are always flip-flops.

Some settings are shared by the whole bank:
- whether set/reset is synchronous,
- whether the primary cells are latches,
- the clock polarity.

Each cell has its own reset-sense bit and its own inverted power-up bit. The clock-polarity bit reads differently for flip-flops and for latches. Selecting latch mode together with synchronous set/reset is an illegal combination. In that case the bank raises `cfg_illegal` and handles set/reset asynchronously.

Top module: `slice_store_bank`

## Requirements
- R1: The configuration word is captured only on a rising `clk` edge while `cfg_load` is 1. Changes to `cfg_word` while `cfg_load` is 0 have no effect on the bank.
- R2: While `ginit` is 1, every cell shows the complement of its init bit at once. Init bits are at word bits [3+2N-1:3+N], cell k at bit 3+N+k, where N is the cell count. `ginit` overrides `sr`, `ce` and `d`.
- R3: For a flip-flop cell, `q` takes `d` at an active clock edge only when its `ce` bit is 1. With `ce` at 0 the cell holds its value.
- R4: With the clock-polarity bit (word bit 2) at 0, flip-flop cells capture on the rising `clk` edge. With it at 1 they capture on the falling edge. Secondary cells (indices N_PRI and above) use this meaning in every mode.
- R5: With the latch bit (word bit 1) at 1, primary cells (indices 0 to N_PRI-1) are transparent while `ce` is 1 and the gate is open, and hold otherwise. The gate is open while `clk` is high when bit 2 is 1, and while `clk` is low when bit 2 is 0.
- R6: Asserting `sr` drives cell k to the complement of its reset-sense bit, which is word bit 3+k. A sense bit of 1 clears the cell and a sense bit of 0 presets it.
- R7: With the sync bit (word bit 0) at 1 and the latch bit at 0, `sr` changes the cells only at their active clock edge.
- R8: With the sync bit at 0, or with the latch bit at 1, `sr` changes every cell immediately, without waiting for a clock edge.
- R9: `sr` takes priority over `ce`, in both synchronous and asynchronous handling.
- R10: `cfg_illegal` is 1 exactly when the stored word has both the sync bit and the latch bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, which is also the latch gate source |
| cfg_load | input | 1 | Enables configuration capture on the rising edge |
| cfg_word | input | 3+2*(NUM_PRI+NUM_SEC) | Configuration word: bit 0 sync, bit 1 latch, bit 2 clock polarity, then the reset-sense bits, then the inverted init bits |
| ginit | input | 1 | Global initialise, which loads the power-up values |
| sr | input | 1 | Shared set/reset |
| ce | input | NUM_PRI+NUM_SEC | Per-cell enable |
| d | input | NUM_PRI+NUM_SEC | Per-cell data |
| q | output | NUM_PRI+NUM_SEC | Per-cell stored value |
| cfg_illegal | output | 1 | Stored configuration combines latch mode with synchronous set/reset |

## Verification
The bench sweeps every combination of the three shared mode bits. Each combination is run with two different sets of per-cell sense and init patterns, so that clear and preset cells sit side by side.

Within each run, the bench samples the outputs at two points:
- in the middle of the high clock phase,
- just after the falling edge.

Comparing these two points tells rising capture apart from falling capture, and open latches apart from closed ones.

Set/reset is applied while the enable is low and again while it is high. Sampling before the first active edge separates immediate handling from edge-timed handling. Rewriting `cfg_word` with `cfg_load` low shows that the stored word is unaffected.

// File: rtl/ssb_pkg.sv
`timescale 1ns / 1ps
package ssb_pkg;

  // Shared mode field positions inside the configuration word
  localparam int unsigned SYNC_BIT  = 0;
  localparam int unsigned LATCH_BIT = 1;
  localparam int unsigned INV_BIT   = 2;
  localparam int unsigned MODE_W    = 3;

  typedef struct packed {
    logic clk_inv;   // edge / gate polarity select
    logic latch;     // primary cells act as latches
    logic sync;      // set/reset timed by the clock edge
  } ssb_mode_t;

endpackage

// File: rtl/ssb_cfg.sv
`timescale 1ns / 1ps
module ssb_cfg
  import ssb_pkg::*;
#(
  parameter int unsigned NCELL = 8,
  localparam int unsigned CFG_W = MODE_W + 2 * NCELL
) (
  input  logic             clk,
  input  logic             load,
  input  logic [CFG_W-1:0] word,
  output ssb_mode_t        mode,
  output logic [NCELL-1:0] rst_zero,
  output logic [NCELL-1:0] init_n,
  output logic             sr_on_edge,
  output logic             illegal
);

  localparam int unsigned SENSE_LSB = MODE_W;
  localparam int unsigned INIT_LSB  = MODE_W + NCELL;

  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (load) word_q <= word;
  end

  always_comb begin
    mode.sync    = word_q[SYNC_BIT];
    mode.latch   = word_q[LATCH_BIT];
    mode.clk_inv = word_q[INV_BIT];
  end

  assign rst_zero   = word_q[SENSE_LSB +: NCELL];
  assign init_n     = word_q[INIT_LSB +: NCELL];
  // Latch mode forces asynchronous handling of set/reset
  assign sr_on_edge = mode.sync & ~mode.latch;
  assign illegal    = mode.sync & mode.latch;

endmodule

// File: rtl/ssb_flop.sv
`timescale 1ns / 1ps
module ssb_flop (
  input  logic clk,
  input  logic clk_inv,
  input  logic ginit,
  input  logic sr,
  input  logic sr_on_edge,
  input  logic ce,
  input  logic d,
  input  logic init_val,
  input  logic sr_val,
  output logic q
);

  logic eclk;
  logic async_hit;

  assign eclk      = clk ^ clk_inv;
  assign async_hit = ginit | (sr & ~sr_on_edge);

  always_ff @(posedge eclk or posedge async_hit) begin
    if (async_hit)  q <= ginit ? init_val : sr_val;
    else if (sr)    q <= sr_val;
    else if (ce)    q <= d;
  end

endmodule

// File: rtl/ssb_latch.sv
`timescale 1ns / 1ps
module ssb_latch (
  input  logic clk,
  input  logic clk_inv,
  input  logic ginit,
  input  logic sr,
  input  logic ce,
  input  logic d,
  input  logic init_val,
  input  logic sr_val,
  output logic q
);

  // Polarity bit 1: open while clk high; bit 0: open while clk low
  logic gate_open;
  assign gate_open = ~(clk ^ clk_inv);

  always_latch begin
    if (ginit)                 q <= init_val;
    else if (sr)               q <= sr_val;
    else if (gate_open && ce)  q <= d;
  end

endmodule

// File: rtl/slice_store_bank.sv
`timescale 1ns / 1ps
module slice_store_bank
  import ssb_pkg::*;
#(
  parameter int unsigned NUM_PRI = 4,
  parameter int unsigned NUM_SEC = 4,
  localparam int unsigned NCELL  = NUM_PRI + NUM_SEC,
  localparam int unsigned CFG_W  = MODE_W + 2 * NCELL
) (
  input  logic             clk,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             ginit,
  input  logic             sr,
  input  logic [NCELL-1:0] ce,
  input  logic [NCELL-1:0] d,
  output logic [NCELL-1:0] q,
  output logic             cfg_illegal
);

  ssb_mode_t        mode;
  logic [NCELL-1:0] rst_zero;
  logic [NCELL-1:0] init_n;
  logic             sr_on_edge;
  logic [NCELL-1:0] ff_q;

  ssb_cfg #(.NCELL(NCELL)) u_cfg (
    .clk        (clk),
    .load       (cfg_load),
    .word       (cfg_word),
    .mode       (mode),
    .rst_zero   (rst_zero),
    .init_n     (init_n),
    .sr_on_edge (sr_on_edge),
    .illegal    (cfg_illegal)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic init_val;
    logic sr_val;
    assign init_val = ~init_n[i];
    assign sr_val   = ~rst_zero[i];

    ssb_flop u_ff (
      .clk        (clk),
      .clk_inv    (mode.clk_inv),
      .ginit      (ginit),
      .sr         (sr),
      .sr_on_edge (sr_on_edge),
      .ce         (ce[i]),
      .d          (d[i]),
      .init_val   (init_val),
      .sr_val     (sr_val),
      .q          (ff_q[i])
    );

    if (i < NUM_PRI) begin : g_pri
      logic lat_q;
      ssb_latch u_lat (
        .clk      (clk),
        .clk_inv  (mode.clk_inv),
        .ginit    (ginit),
        .sr       (sr),
        .ce       (ce[i]),
        .d        (d[i]),
        .init_val (init_val),
        .sr_val   (sr_val),
        .q        (lat_q)
      );
      assign q[i] = mode.latch ? lat_q : ff_q[i];
    end else begin : g_sec
      assign q[i] = ff_q[i];
    end
  end

endmodule

// File: rtl/slice_store_bank_chk.sv
`timescale 1ns / 1ps
module slice_store_bank_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         cfg_load,
  input logic         ginit,
  input logic         sr,
  input logic [N-1:0] ce,
  input logic [N-1:0] q,
  input logic         cfg_illegal,
  input logic         sr_on_edge,
  input logic         latch_on,
  input logic         clk_inv,
  input logic [N-1:0] rst_zero,
  input logic [N-1:0] init_n
);

  // Armed once the bank has been initialised at least once
  logic armed = 1'b0;
  always @(posedge clk) if (ginit) armed <= 1'b1;

  // R1: stored configuration only moves after a load cycle
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!armed)
    !$past(cfg_load) |-> $stable(cfg_illegal));

  // R2: initialise shows the power-up values
  p_init_load_r2: assert property (@(posedge clk) disable iff (!armed || cfg_load)
    ginit |-> (q == ~init_n));

  // R3: rising-edge flip-flops with enable low keep their value
  p_ce_hold_r3: assert property (@(posedge clk) disable iff (!armed || cfg_load)
    (!latch_on && !clk_inv && !sr && !$past(sr) && !ginit && !$past(ginit)
     && !$past(cfg_load))
    |-> ((q & ~$past(ce)) == ($past(q) & ~$past(ce))));

  // R7: edge-timed set/reset has taken effect one edge later
  p_sync_sr_r7: assert property (@(posedge clk) disable iff (!armed || cfg_load)
    (sr_on_edge && !clk_inv && $past(sr) && !$past(ginit) && !ginit
     && !$past(cfg_load))
    |-> (q == ~rst_zero));

  // R8: immediate set/reset holds every cell at its reset value
  p_async_sr_r8: assert property (@(posedge clk) disable iff (!armed || cfg_load)
    (!sr_on_edge && sr && $past(sr) && !ginit && !$past(ginit)
     && !$past(cfg_load))
    |-> (q == ~rst_zero));

endmodule

bind slice_store_bank slice_store_bank_chk #(.N(NCELL)) u_chk (
  .clk         (clk),
  .cfg_load    (cfg_load),
  .ginit       (ginit),
  .sr          (sr),
  .ce          (ce),
  .q           (q),
  .cfg_illegal (cfg_illegal),
  .sr_on_edge  (sr_on_edge),
  .latch_on    (mode.latch),
  .clk_inv     (mode.clk_inv),
  .rst_zero    (rst_zero),
  .init_n      (init_n)
);

// File: tb/slice_store_bank_tb.sv
`timescale 1ns / 1ps
module slice_store_bank_tb;

  localparam int N  = 8;
  localparam int NP = 4;
  localparam int CW = 3 + 2 * N;

  logic          clk = 1'b0;
  logic          cfg_load = 1'b0;
  logic [CW-1:0] cfg_word = '0;
  logic          ginit = 1'b0;
  logic          sr = 1'b0;
  logic [N-1:0]  ce = '0;
  logic [N-1:0]  d = '0;
  logic [N-1:0]  q;
  logic          cfg_illegal;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  slice_store_bank #(.NUM_PRI(NP), .NUM_SEC(N - NP)) u_dut (
    .clk(clk), .cfg_load(cfg_load), .cfg_word(cfg_word), .ginit(ginit),
    .sr(sr), .ce(ce), .d(d), .q(q), .cfg_illegal(cfg_illegal)
  );

  task automatic check_v(input string req, input logic [N-1:0] act,
                         input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_b(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cfg_illegal actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One time unit after a rising edge: clk high until +1 later
  task automatic to_p();
    @(posedge clk);
    #1;
  endtask

  task automatic run(input bit s, input bit l, input bit v,
                     input logic [N-1:0] rs, input logic [N-1:0] inn);
    logic [N-1:0] a, b, c, srv, lm, e;
    bit asy;
    a = inn; b = ~inn; c = rs; srv = ~rs;
    lm = l ? N'((1 << NP) - 1) : '0;
    asy = !s || l;

    to_p();
    cfg_word = {inn, rs, v, l, s};
    cfg_load = 1'b1; ce = '0; sr = 1'b0; ginit = 1'b0; d = '0;
    to_p();
    cfg_load = 1'b0;
    #0.5 check_b("R10", cfg_illegal, l & s);
    cfg_word = ~cfg_word;                  // R1: ignored without load
    to_p(); to_p();
    check_b("R1", cfg_illegal, l & s);

    // R2: initialise overrides sr, ce and d
    ginit = 1'b1; sr = 1'b1; ce = '1; d = a;
    #0.5 check_v("R2 immediate", q, ~inn);
    to_p();
    check_v("R2 held over edges", q, ~inn);
    ginit = 1'b0; sr = 1'b0; ce = '0;
    to_p();
    check_v("R3 hold after init", q, ~inn);

    // R3/R5: capture and hold
    ce = '1; d = a;
    to_p(); to_p();
    check_v("R3 capture", q, a);
    ce = '0; d = ~a;
    to_p(); to_p();
    check_v("R3 enable low holds", q, a);

    // R4/R5: polarity, sampled in high phase then after falling edge
    ce = '1; d = b;
    e = (lm & (v ? b : a)) | (~lm & a);
    #0.5 check_v("R5 gate high phase", q, e);
    e = (lm & b) | (~lm & (v ? b : a));
    #1 check_v("R4 after falling edge", q, e);
    to_p();
    check_v("R4 full cycle", q, b);

    // R6/R7/R8/R9: set/reset with enable low
    d = c; ce = '0; sr = 1'b1;
    #0.5 check_v("R8 before any edge", q, asy ? srv : b);
    #1 check_v("R7 after falling edge", q, (asy || v) ? srv : b);
    to_p();
    check_v("R6 reset value", q, srv);
    sr = 1'b0;
    to_p();
    check_v("R9 sr beat enable low", q, srv);
    ce = '1;
    to_p(); to_p();
    check_v("R3 capture after release", q, c);

    // R9: set/reset wins over enable high
    sr = 1'b1; d = ~c;
    to_p(); to_p();
    check_v("R9 sr beat enable high", q, srv);
    sr = 1'b0; ce = '0;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) begin
      logic [N-1:0] rs, inn;
      rs  = (k >= 8) ? 8'h39 : 8'hA6;
      inn = (k >= 8) ? 8'hC3 : 8'h5C;
      run(k[0], k[1], k[2], rs, inn);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule